// File: doc/BRIEF.md
# Branch Condition and Timing Evaluator

This block looks at one 8-bit opcode together with the four processor status flags: sign, zero, parity and carry. For a control-transfer instruction (jump, call, return or restart) it decides whether the transfer happens. It also reports how many clock cycles the instruction takes, an instruction-class code, and for a restart the fixed target address. It does not fetch the operand address, touch the stack or move the program counter. A sequencer reads these results to pick its next state and to count cycles.

The decision logic is purely combinational. All four results are captured in one output register, so each result appears one clock after its opcode and flags were presented.

Top module: `bcte_eval`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero on that edge. Otherwise the outputs at each edge reflect the `opcode` and `flags` sampled on that same edge, one cycle of latency.
- R2: `flags` bit 3 is sign, bit 2 is zero, bit 1 is parity (1 = even) and bit 0 is carry. The condition field is opcode bits 5..3, coded as follows:
  - 000 = not zero
  - 001 = zero
  - 010 = no carry
  - 011 = carry
  - 100 = parity odd (parity flag clear)
  - 101 = parity even
  - 110 = positive (sign clear)
  - 111 = minus
- R3: An opcode 11ccc010 is a conditional jump. `taken` follows condition ccc, and `cycles` is 10 whether or not it is taken.
- R4: An opcode 11ccc100 is a conditional call. `taken` follows ccc. `cycles` is 17 when taken and 11 when not.
- R5: An opcode 11ccc000 is a conditional return. `taken` follows ccc. `cycles` is 11 when taken and 5 when not.
- R6: The unconditional forms are 0xC3 (jump, 10 cycles), 0xCD (call, 17 cycles) and 0xC9 (return, 10 cycles). Each sets `taken`=1 whatever the flags are.
- R7: An opcode 11aaa111 is a restart. It gives `taken`=1, `cycles`=11 and `target`=aaa×8 zero-extended to 16 bits. For every other opcode `target` is 0.
- R8: Every opcode outside the classes above gives class "other", `taken`=0 and `cycles`=0, and the flags have no effect on it. This includes the 11xxx001/011/101 values other than C9, C3 and CD.
- R9: The `iclass` codes are:
  - 0 = other
  - 1 = jump
  - 2 = conditional jump
  - 3 = call
  - 4 = conditional call
  - 5 = return
  - 6 = conditional return
  - 7 = restart

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction byte |
| flags | input | 4 | {sign, zero, parity, carry} |
| taken | output | 1 | Transfer happens (registered) |
| cycles | output | 5 | Clock cycle count of the instruction (registered) |
| iclass | output | 3 | Instruction class code (registered) |
| target | output | 16 | Restart target address, else 0 (registered) |

## Verification
Opcode bits 5..3 serve two purposes. For conditional forms they select the condition, and for restarts they are the vector. The same opcode bits therefore drive both the condition multiplexer and the target path in the same cycle. The bench sends every one of the 256 opcodes with all 16 flag combinations, so each field value is tried in both roles. It checks that `target` is nonzero only for restarts, and that `taken` and `cycles` agree with the condition only for the conditional forms.

// File: rtl/bcte_pkg.sv
package bcte_pkg;

    localparam int OPC_W = 8;
    localparam int CYC_W = 5;
    localparam int FLD_W = 3;
    localparam int NCOND = 1 << FLD_W;

    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_JMP   = 3'd1,
        CLS_JCC   = 3'd2,
        CLS_CALL  = 3'd3,
        CLS_CCC   = 3'd4,
        CLS_RET   = 3'd5,
        CLS_RCC   = 3'd6,
        CLS_RST   = 3'd7
    } iclass_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic parity;
        logic carry;
    } flags_t;

    typedef struct packed {
        iclass_e           cls;
        logic [FLD_W-1:0]  field;
    } decode_t;

    localparam logic [CYC_W-1:0] CYC_JUMP      = 5'd10;
    localparam logic [CYC_W-1:0] CYC_CALL      = 5'd17;
    localparam logic [CYC_W-1:0] CYC_CALL_SKIP = 5'd11;
    localparam logic [CYC_W-1:0] CYC_RET       = 5'd10;
    localparam logic [CYC_W-1:0] CYC_RET_TAKEN = 5'd11;
    localparam logic [CYC_W-1:0] CYC_RET_SKIP  = 5'd5;
    localparam logic [CYC_W-1:0] CYC_RESTART   = 5'd11;

    localparam logic [OPC_W-1:0] OPC_JMP  = 8'hC3;
    localparam logic [OPC_W-1:0] OPC_CALL = 8'hCD;
    localparam logic [OPC_W-1:0] OPC_RET  = 8'hC9;

    function automatic logic [FLD_W-1:0] mid_field(input logic [OPC_W-1:0] op);
        return op[5:3];
    endfunction

    function automatic logic is_cond_class(input iclass_e c);
        return (c == CLS_JCC) || (c == CLS_CCC) || (c == CLS_RCC);
    endfunction

endpackage

// File: rtl/bcte_decode.sv
module bcte_decode
    import bcte_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    output decode_t          dec
);
    logic prefix_ok;
    assign prefix_ok = (op[7:6] == 2'b11);

    always_comb begin
        dec.field = mid_field(op);
        dec.cls   = CLS_OTHER;
        if (prefix_ok) begin
            unique case (op[2:0])
                3'b000: dec.cls = CLS_RCC;
                3'b010: dec.cls = CLS_JCC;
                3'b100: dec.cls = CLS_CCC;
                3'b111: dec.cls = CLS_RST;
                3'b011: dec.cls = (op == OPC_JMP)  ? CLS_JMP  : CLS_OTHER;
                3'b101: dec.cls = (op == OPC_CALL) ? CLS_CALL : CLS_OTHER;
                3'b001: dec.cls = (op == OPC_RET)  ? CLS_RET  : CLS_OTHER;
                default: dec.cls = CLS_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/bcte_cond.sv
module bcte_cond
    import bcte_pkg::*;
(
    input  flags_t           fl,
    input  logic [FLD_W-1:0] field,
    output logic             met
);
    // Pair index = field[2:1]: 0 zero, 1 carry, 2 parity, 3 sign.
    // field[0] = 0 tests the flag clear, 1 tests it set.
    logic [NCOND/2-1:0] pair_flag;
    logic [NCOND-1:0]   cond_vec;

    assign pair_flag = {fl.sign, fl.parity, fl.carry, fl.zero};

    for (genvar i = 0; i < NCOND; i++) begin : g_cond
        if (i % 2 == 1) begin : g_set
            assign cond_vec[i] = pair_flag[i/2];
        end else begin : g_clr
            assign cond_vec[i] = ~pair_flag[i/2];
        end
    end

    assign met = cond_vec[field];
endmodule

// File: rtl/bcte_timing.sv
module bcte_timing
    import bcte_pkg::*;
(
    input  iclass_e          cls,
    input  logic             met,
    output logic             take,
    output logic [CYC_W-1:0] ncyc
);
    always_comb begin
        take = 1'b0;
        ncyc = '0;
        unique case (cls)
            CLS_JMP:  begin take = 1'b1; ncyc = CYC_JUMP;    end
            CLS_JCC:  begin take = met;  ncyc = CYC_JUMP;    end
            CLS_CALL: begin take = 1'b1; ncyc = CYC_CALL;    end
            CLS_CCC:  begin take = met;  ncyc = met ? CYC_CALL : CYC_CALL_SKIP; end
            CLS_RET:  begin take = 1'b1; ncyc = CYC_RET;     end
            CLS_RCC:  begin take = met;  ncyc = met ? CYC_RET_TAKEN : CYC_RET_SKIP; end
            CLS_RST:  begin take = 1'b1; ncyc = CYC_RESTART; end
            default:  begin take = 1'b0; ncyc = '0;          end
        endcase
    end
endmodule

// File: rtl/bcte_eval.sv
module bcte_eval
    import bcte_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int VEC_SHIFT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        opcode,
    input  logic [3:0]        flags,
    output logic              taken,
    output logic [4:0]        cycles,
    output logic [2:0]        iclass,
    output logic [ADDR_W-1:0] target
);
    localparam int PAD_W = ADDR_W - FLD_W - VEC_SHIFT;

    decode_t           dec;
    flags_t            fl;
    logic              met;
    logic              take_c;
    logic [CYC_W-1:0]  ncyc_c;
    logic [ADDR_W-1:0] tgt_c;

    assign fl = flags_t'(flags);

    bcte_decode u_dec (
        .op  (opcode),
        .dec (dec)
    );

    bcte_cond u_cond (
        .fl    (fl),
        .field (dec.field),
        .met   (met)
    );

    bcte_timing u_tim (
        .cls  (dec.cls),
        .met  (met),
        .take (take_c),
        .ncyc (ncyc_c)
    );

    assign tgt_c = (dec.cls == CLS_RST)
                 ? {{PAD_W{1'b0}}, dec.field, {VEC_SHIFT{1'b0}}}
                 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken  <= 1'b0;
            cycles <= '0;
            iclass <= CLS_OTHER;
            target <= '0;
        end else begin
            taken  <= take_c;
            cycles <= ncyc_c;
            iclass <= dec.cls;
            target <= tgt_c;
        end
    end
endmodule

// File: rtl/bcte_chk.sv
module bcte_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  opcode,
    input logic [3:0]  flags,
    input logic        taken,
    input logic [4:0]  cycles,
    input logic [2:0]  iclass,
    input logic [15:0] target
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!taken && cycles == 5'd0 && iclass == 3'd0 && target == 16'd0));

    assert_latency_class_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == 8'hC3) |-> iclass == 3'd1);

    assert_jump_cycles_R3: assert property (@(posedge clk) disable iff (rst)
        (iclass == 3'd2 || iclass == 3'd1) |-> cycles == 5'd10);

    assert_call_cycles_R4: assert property (@(posedge clk) disable iff (rst)
        (iclass == 3'd4) |-> (cycles == (taken ? 5'd17 : 5'd11)));

    assert_ret_cycles_R5: assert property (@(posedge clk) disable iff (rst)
        (iclass == 3'd6) |-> (cycles == (taken ? 5'd11 : 5'd5)));

    assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (iclass == 3'd1 || iclass == 3'd3 || iclass == 3'd5) |-> taken);

    assert_target_only_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (iclass != 3'd7) |-> target == 16'd0);

    assert_restart_timing_R7: assert property (@(posedge clk) disable iff (rst)
        (iclass == 3'd7) |-> (taken && cycles == 5'd11));

    assert_other_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (iclass == 3'd0) |-> (!taken && cycles == 5'd0));

    assert_flag_blind_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode[7:6]) != 2'b11) |-> (iclass == 3'd0 && !taken));
endmodule

bind bcte_eval bcte_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .flags  (flags),
    .taken  (taken),
    .cycles (cycles),
    .iclass (iclass),
    .target (target)
);

// File: tb/sim_bcte_eval.sv
`timescale 1ns/1ps
module sim_bcte_eval;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  opcode;
    logic [3:0]  flags;
    logic        taken;
    logic [4:0]  cycles;
    logic [2:0]  iclass;
    logic [15:0] target;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bcte_eval u0 (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .flags  (flags),
        .taken  (taken),
        .cycles (cycles),
        .iclass (iclass),
        .target (target)
    );

    // R2: condition ccc against flags {S,Z,P,C}
    function automatic bit cond_ok(input logic [2:0] c, input logic [3:0] f);
        case (c)
            3'd0: return !f[2];
            3'd1: return  f[2];
            3'd2: return !f[0];
            3'd3: return  f[0];
            3'd4: return !f[1];
            3'd5: return  f[1];
            3'd6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    function automatic void expect_of(input logic [7:0] op, input logic [3:0] f,
                                      output bit t, output logic [4:0] cy,
                                      output logic [2:0] cl, output logic [15:0] tg,
                                      output string req);
        bit m;
        m = cond_ok(op[5:3], f);
        t = 0; cy = 0; cl = 0; tg = 0; req = "R8";
        if (op == 8'hC3)      begin t = 1; cy = 10; cl = 1; req = "R6"; end
        else if (op == 8'hCD) begin t = 1; cy = 17; cl = 3; req = "R6"; end
        else if (op == 8'hC9) begin t = 1; cy = 10; cl = 5; req = "R6"; end
        else if (op[7:6] == 2'b11) begin
            case (op[2:0])
                3'b010: begin t = m; cy = 10; cl = 2; req = "R3/R2"; end
                3'b100: begin t = m; cy = m ? 17 : 11; cl = 4; req = "R4/R2"; end
                3'b000: begin t = m; cy = m ? 11 : 5;  cl = 6; req = "R5/R2"; end
                3'b111: begin t = 1; cy = 11; cl = 7; tg = {10'd0, op[5:3], 3'd0}; req = "R7"; end
                default: ;
            endcase
        end
    endfunction

    task automatic apply(input logic [7:0] op, input logic [3:0] f);
        bit e_t; logic [4:0] e_cy; logic [2:0] e_cl; logic [15:0] e_tg; string req;
        @(negedge clk);
        opcode = op;
        flags  = f;
        expect_of(op, f, e_t, e_cy, e_cl, e_tg, req);
        @(negedge clk);
        n_checks++;
        if (taken !== e_t || cycles !== e_cy || iclass !== e_cl || target !== e_tg) begin
            n_fail++;
            $display("FAIL %s R9 op=%02h fl=%01h: got t=%0b cy=%0d cl=%0d tg=%04h exp t=%0b cy=%0d cl=%0d tg=%04h",
                     req, op, f, taken, cycles, iclass, target, e_t, e_cy, e_cl, e_tg);
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed   = 32'd1234;
        void'($urandom(seed));
        rst    = 1'b1;
        opcode = 8'hC3;
        flags  = 4'hF;
        repeat (3) @(negedge clk);
        n_checks++;
        if (taken !== 1'b0 || cycles !== 5'd0 || iclass !== 3'd0 || target !== 16'd0) begin
            n_fail++;
            $display("FAIL R1 reset: got t=%0b cy=%0d cl=%0d tg=%04h exp all zero",
                     taken, cycles, iclass, target);
        end
        rst = 1'b0;

        // Directed corners: restart vectors 0 and 7, call taken/skipped
        apply(8'hC7, 4'h0);
        apply(8'hFF, 4'hF);
        apply(8'hDC, 4'h1);
        apply(8'hDC, 4'h0);
        apply(8'hCB, 4'hF);
        apply(8'hD9, 4'hF);

        // Exhaustive: every opcode with every flag pattern
        for (int o = 0; o < 256; o++)
            for (int f = 0; f < 16; f++)
                apply(o[7:0], f[3:0]);

        // Random mix, biased toward the 11xxxxxx space
        for (int k = 0; k < 2000; k++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (k % 2 == 0) op[7:6] = 2'b11;
            apply(op, 4'($urandom));
        end

        // R1: reset mid-stream clears on the next edge
        @(negedge clk);
        opcode = 8'hCD;
        rst    = 1'b1;
        @(negedge clk);
        n_checks++;
        if (taken !== 1'b0 || cycles !== 5'd0 || iclass !== 3'd0) begin
            n_fail++;
            $display("FAIL R1 mid reset: got t=%0b cy=%0d cl=%0d exp 0 0 0", taken, cycles, iclass);
        end
        rst = 1'b0;
        apply(8'hCD, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule